// File: doc/BRIEF.md
# Clause 45 MDIO Management Master

This block drives a two-wire management bus to external PHYs using Clause 45 indirect addressing. A host on a simple synchronous register port programs a clock divider, a target (port and device address), and then starts bus transactions by writing registers. Writing the register-number register sends an address frame. Writing the data register sends a write frame. Setting the read-request bit in the control register sends a read frame, and the 16 bits that come back are stored in the data register.

MDC is made from the system clock by a programmable divider and stays low between frames. Each frame is 64 MDC periods long. The master changes MDIO after the falling MDC edge. For reads it stops driving MDIO at the turnaround, and it samples MDIO on the rising edge of MDC. Two separate busy flags are kept: one for the address phase and one for the data phase. If the PHY does not pull the second turnaround bit low, a read-error flag is set and the data register is filled with all ones.

Top module: `mdio_c45_master`

## Requirements
- R1: After reset, the status register (index 0) reads 0x00006400: divider 100 in bits [15:8], busy bit 0 clear and error bit 1 clear. The data register (index 3) reads 0. MDC and the MDIO output enable are low.
- R2: While a frame runs, MDC has a period of 2×(divider+1) system clocks. MDC is low whenever no frame is in progress.
- R3: A bus write to the address register (index 2) sends a frame, MSB first. The frame is 32 ones, start 00, opcode 00, the 5-bit port address (control bits [12:8]), the 5-bit device address (control bits [4:0]), turnaround 10, and bits [15:0] of the written value. Status bit 0 is set while this frame runs.
- R4: A bus write to the data register sends the same frame shape with opcode 01 and the written 16-bit value. Data register bit 31 is set while this frame runs.
- R5: A control write with bit 15 set sends a frame with opcode 11. The master drives the first 46 bits and then releases MDIO for the last 18 bits. When the frame ends, data register bits [15:0] hold the 16 bits sampled after the turnaround, MSB first. Data register bit 31 is set while this frame runs.
- R6: If the second turnaround bit of a read is sampled high, status bit 1 is set and data register bits [15:0] become 0xFFFF. The next read that gets a response clears status bit 1.
- R7: Any bus write made while a frame is in progress is ignored. It starts no frame and changes no register.
- R8: The read-request bit always reads back as 0. The port and device fields keep their written values after a read is launched.
- R9: A frame holds its busy flag for exactly 128×(divider+1) system clocks after the launching write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 2 | Register index (0 status, 1 control, 2 address, 3 data) |
| bus_wdata_i | input | 32 | Register write data |
| bus_rdata_o | output | 32 | Read data of the indexed register (combinational) |
| mdc_o | output | 1 | Management clock |
| mdio_i | input | 1 | Management data in, sampled from the pad |
| mdio_o | output | 1 | Management data out |
| mdio_oe_o | output | 1 | Drive enable for mdio_o |

## Verification
The bench builds the block with its default parameters: an 8-bit divider that resets to 100. It reprograms the divider to 0, 1, 2, 3 and 100 across the accesses. The small divider values keep each 64-bit frame short, so a table of mixed address, write and read accesses can be checked bit by bit, including the highest port and device codes. The value 100 covers the full-length frame timing. A PHY model in the bench either responds with a chosen value or stays silent, and this exercises both the captured-data path and the error fill.

// File: rtl/mdio_c45_pkg.sv
package mdio_c45_pkg;
  localparam int PHY_AW      = 5;
  localparam int PAYLOAD_W   = 16;
  localparam int PRE_BITS    = 32;
  localparam int FRAME_BITS  = PRE_BITS + 4 + 2*PHY_AW + 2 + PAYLOAD_W;
  localparam int IDX_W       = $clog2(FRAME_BITS);
  localparam int RELEASE_IDX = FRAME_BITS - PAYLOAD_W - 2;
  localparam int TA2_IDX     = RELEASE_IDX + 1;

  localparam logic [1:0] REG_STAT = 2'd0;
  localparam logic [1:0] REG_CTRL = 2'd1;
  localparam logic [1:0] REG_ADDR = 2'd2;
  localparam logic [1:0] REG_DATA = 2'd3;

  localparam int STAT_BUSY_BIT = 0;
  localparam int STAT_ERR_BIT  = 1;
  localparam int STAT_DIV_LSB  = 8;
  localparam int CTRL_DEV_LSB  = 0;
  localparam int CTRL_PORT_LSB = 8;
  localparam int CTRL_RD_BIT   = 15;
  localparam int DATA_BUSY_BIT = 31;

  typedef enum logic [1:0] {
    OP_ADDR  = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b11
  } mdio_op_e;
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             mdc_o,
  output logic             rise_o,
  output logic             fall_o
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             mdc_q, mdc_d;
  logic             wrap;

  assign wrap   = run_i && (cnt_q == div_i);
  assign rise_o = wrap && !mdc_q;
  assign fall_o = wrap &&  mdc_q;
  assign mdc_o  = mdc_q;

  always_comb begin
    cnt_d = cnt_q;
    mdc_d = mdc_q;
    if (!run_i) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else if (wrap) begin
      cnt_d = '0;
      mdc_d = !mdc_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  // R2: the phase counter never passes the programmed half period
  a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> (cnt_q <= div_i));
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_c45_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  mdio_op_e             op_i,
  input  logic [PHY_AW-1:0]    port_i,
  input  logic [PHY_AW-1:0]    dev_i,
  input  logic [PAYLOAD_W-1:0] payload_i,
  input  logic                 rise_i,
  input  logic                 fall_i,
  input  logic                 mdio_i,
  output logic                 active_o,
  output logic                 mdo_o,
  output logic                 oe_o,
  output logic                 done_o,
  output logic [PAYLOAD_W-1:0] rd_data_o,
  output logic                 rd_err_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);
  localparam logic [IDX_W-1:0] REL_IDX  = IDX_W'(RELEASE_IDX);
  localparam logic [IDX_W-1:0] TA2      = IDX_W'(TA2_IDX);

  logic                  active_q, active_d;
  logic                  is_rd_q, is_rd_d;
  logic [IDX_W-1:0]      idx_q, idx_d;
  logic [FRAME_BITS-1:0] sh_q, sh_d;
  logic [PAYLOAD_W-1:0]  rdat_q, rdat_d;
  logic                  err_q, err_d;

  assign active_o  = active_q;
  assign mdo_o     = sh_q[FRAME_BITS-1];
  assign oe_o      = active_q && !(is_rd_q && (idx_q >= REL_IDX));
  assign done_o    = active_q && fall_i && (idx_q == LAST_IDX);
  assign rd_data_o = rdat_q;
  assign rd_err_o  = err_q;

  always_comb begin
    active_d = active_q;
    is_rd_d  = is_rd_q;
    idx_d    = idx_q;
    sh_d     = sh_q;
    rdat_d   = rdat_q;
    err_d    = err_q;
    if (!active_q) begin
      if (start_i) begin
        active_d = 1'b1;
        is_rd_d  = (op_i == OP_READ);
        idx_d    = '0;
        err_d    = 1'b0;
        sh_d     = {{PRE_BITS{1'b1}}, 2'b00, op_i, port_i, dev_i, 2'b10, payload_i};
      end
    end else begin
      if (rise_i && is_rd_q) begin
        if (idx_q == TA2) err_d = mdio_i;
        if (idx_q > TA2)  rdat_d = {rdat_q[PAYLOAD_W-2:0], mdio_i};
      end
      if (fall_i) begin
        if (idx_q == LAST_IDX) begin
          active_d = 1'b0;
        end else begin
          idx_d = idx_q + 1'b1;
          sh_d  = {sh_q[FRAME_BITS-2:0], 1'b1};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      is_rd_q  <= 1'b0;
      idx_q    <= '0;
      sh_q     <= '0;
      rdat_q   <= '0;
      err_q    <= 1'b0;
    end else begin
      active_q <= active_d;
      is_rd_q  <= is_rd_d;
      idx_q    <= idx_d;
      sh_q     <= sh_d;
      rdat_q   <= rdat_d;
      err_q    <= err_d;
    end
  end

  // R9: a frame only ends on a falling MDC edge
  a_r9_end_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active_q) |-> $past(fall_i));
endmodule

// File: rtl/mdio_c45_master.sv
module mdio_c45_master
  import mdio_c45_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int DIV_RST = 100
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr_i,
  input  logic [1:0]  bus_addr_i,
  input  logic [31:0] bus_wdata_i,
  output logic [31:0] bus_rdata_o,
  output logic        mdc_o,
  input  logic        mdio_i,
  output logic        mdio_o,
  output logic        mdio_oe_o
);
  logic [1:0] rst_pipe;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  logic [DIV_W-1:0]     div_q, div_d;
  logic [PHY_AW-1:0]    port_q, port_d, dev_q, dev_d;
  logic [PAYLOAD_W-1:0] addr_q, addr_d, data_q, data_d;
  logic                 err_q, err_d, abusy_q, abusy_d, dbusy_q, dbusy_d;
  logic                 rdpend_q, rdpend_d;

  logic                 eng_active, eng_done, eng_err, rise, fall, wr_ok, start;
  logic                 wr_rd_req;
  logic [PAYLOAD_W-1:0] eng_rdata;
  logic [PHY_AW-1:0]    st_port, st_dev;
  mdio_op_e             st_op;

  assign wr_ok     = bus_wr_i && !eng_active;
  assign wr_rd_req = (bus_addr_i == REG_CTRL) && bus_wdata_i[CTRL_RD_BIT];
  assign start     = wr_ok && ((bus_addr_i == REG_ADDR) || (bus_addr_i == REG_DATA) || wr_rd_req);
  assign st_op     = (bus_addr_i == REG_ADDR) ? OP_ADDR :
                     (bus_addr_i == REG_DATA) ? OP_WRITE : OP_READ;
  assign st_port   = wr_rd_req ? bus_wdata_i[CTRL_PORT_LSB +: PHY_AW] : port_q;
  assign st_dev    = wr_rd_req ? bus_wdata_i[CTRL_DEV_LSB +: PHY_AW] : dev_q;

  mdio_mdc_gen #(.DIV_W(DIV_W)) mdc_gen_i (
    .clk(clk), .rst_n(rst_int_n), .run_i(eng_active), .div_i(div_q),
    .mdc_o(mdc_o), .rise_o(rise), .fall_o(fall)
  );

  mdio_frame_engine frame_i (
    .clk(clk), .rst_n(rst_int_n), .start_i(start), .op_i(st_op),
    .port_i(st_port), .dev_i(st_dev), .payload_i(bus_wdata_i[PAYLOAD_W-1:0]),
    .rise_i(rise), .fall_i(fall), .mdio_i(mdio_i),
    .active_o(eng_active), .mdo_o(mdio_o), .oe_o(mdio_oe_o), .done_o(eng_done),
    .rd_data_o(eng_rdata), .rd_err_o(eng_err)
  );

  always_comb begin
    div_d = div_q;  port_d = port_q;  dev_d = dev_q;
    addr_d = addr_q; data_d = data_q; err_d = err_q;
    abusy_d = abusy_q; dbusy_d = dbusy_q; rdpend_d = rdpend_q;
    if (wr_ok) begin
      case (bus_addr_i)
        REG_STAT: div_d = bus_wdata_i[STAT_DIV_LSB +: DIV_W];
        REG_CTRL: begin
          port_d = bus_wdata_i[CTRL_PORT_LSB +: PHY_AW];
          dev_d  = bus_wdata_i[CTRL_DEV_LSB +: PHY_AW];
          if (wr_rd_req) begin
            dbusy_d = 1'b1; rdpend_d = 1'b1; err_d = 1'b0;
          end
        end
        REG_ADDR: begin addr_d = bus_wdata_i[PAYLOAD_W-1:0]; abusy_d = 1'b1; end
        default:  begin data_d = bus_wdata_i[PAYLOAD_W-1:0]; dbusy_d = 1'b1; end
      endcase
    end
    if (eng_done) begin
      abusy_d = 1'b0; dbusy_d = 1'b0; rdpend_d = 1'b0;
      if (rdpend_q) begin
        err_d  = eng_err;
        data_d = eng_err ? '1 : eng_rdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      div_q <= DIV_W'(DIV_RST); port_q <= '0; dev_q <= '0;
      addr_q <= '0; data_q <= '0; err_q <= 1'b0;
      abusy_q <= 1'b0; dbusy_q <= 1'b0; rdpend_q <= 1'b0;
    end else begin
      div_q <= div_d; port_q <= port_d; dev_q <= dev_d;
      addr_q <= addr_d; data_q <= data_d; err_q <= err_d;
      abusy_q <= abusy_d; dbusy_q <= dbusy_d; rdpend_q <= rdpend_d;
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    case (bus_addr_i)
      REG_STAT: begin
        bus_rdata_o[STAT_BUSY_BIT] = abusy_q;
        bus_rdata_o[STAT_ERR_BIT]  = err_q;
        bus_rdata_o[STAT_DIV_LSB +: DIV_W] = div_q;
      end
      REG_CTRL: begin
        bus_rdata_o[CTRL_PORT_LSB +: PHY_AW] = port_q;
        bus_rdata_o[CTRL_DEV_LSB +: PHY_AW]  = dev_q;
      end
      REG_ADDR: bus_rdata_o[PAYLOAD_W-1:0] = addr_q;
      default: begin
        bus_rdata_o[PAYLOAD_W-1:0] = data_q;
        bus_rdata_o[DATA_BUSY_BIT] = dbusy_q;
      end
    endcase
  end

  // R2: MDC rests low outside frames
  a_r2_idle_mdc_low: assert property (@(posedge clk) disable iff (!rst_int_n)
    !eng_active |-> !mdc_o);
  // R3/R4: only one phase busy flag at a time
  a_r3_busy_exclusive: assert property (@(posedge clk) disable iff (!rst_int_n)
    $onehot0({abusy_q, dbusy_q}));
  // R9: a busy flag is up exactly while the serializer runs
  a_r9_busy_matches_frame: assert property (@(posedge clk) disable iff (!rst_int_n)
    (abusy_q || dbusy_q) == eng_active);
  // R7: configuration is frozen during a frame
  a_r7_regs_frozen: assert property (@(posedge clk) disable iff (!rst_int_n)
    eng_active |=> ($stable(addr_q) && $stable(div_q) && $stable(port_q) && $stable(dev_q)));
  // R6: a missing response fills the data register with ones
  a_r6_err_fill: assert property (@(posedge clk) disable iff (!rst_int_n)
    (eng_done && rdpend_q && eng_err) |=> (err_q && (data_q == '1)));
endmodule

// File: tb/mdio_c45_master_tb_top.sv
module mdio_c45_master_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] OPA = 2'b00, OPW = 2'b01, OPR = 2'b11;

  // div[36:29] op[28:27] port[26:22] dev[21:17] payload[16:1] present[0]
  localparam logic [36:0] VEC [8] = '{
    {8'd1, OPA, 5'h01, 5'h1E, 16'hA55A, 1'b1},
    {8'd1, OPW, 5'h01, 5'h1E, 16'h1234, 1'b1},
    {8'd1, OPR, 5'h01, 5'h1E, 16'hBEEF, 1'b1},
    {8'd0, OPA, 5'h1F, 5'h00, 16'h0001, 1'b1},
    {8'd2, OPR, 5'h10, 5'h07, 16'h8001, 1'b1},
    {8'd0, OPR, 5'h03, 5'h03, 16'h0000, 1'b0},
    {8'd3, OPW, 5'h1F, 5'h1F, 16'hFFFF, 1'b1},
    {8'd1, OPR, 5'h01, 5'h01, 16'h7FFE, 1'b1}
  };

  logic        clk, rst_n, bus_wr, mdc, mdio_i, mdio_o, mdio_oe;
  logic [1:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;

  mdio_c45_master dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr_i(bus_wr), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .mdc_o(mdc),
    .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe_o(mdio_oe)
  );

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // PHY model and frame capture
  logic        cap_en = 1'b0, rd_mode = 1'b0, phy_here = 1'b0;
  logic [15:0] phy_val = '0;
  logic [63:0] cap_bits, cap_oe;
  int          phy_bit = 0;
  realtime     t_r0, t_r1;

  always @(posedge mdc) if (cap_en) begin
    cap_bits <= {cap_bits[62:0], mdio_o};
    cap_oe   <= {cap_oe[62:0], mdio_oe};
    if (phy_bit == 0) t_r0 = $realtime;
    if (phy_bit == 1) t_r1 = $realtime;
    phy_bit <= phy_bit + 1;
  end

  always @(negedge mdc) begin
    if (cap_en && rd_mode && phy_here && phy_bit == 47) mdio_i <= 1'b0;
    else if (cap_en && rd_mode && phy_here && phy_bit >= 48 && phy_bit < 64)
      mdio_i <= phy_val[63 - phy_bit];
    else mdio_i <= 1'b1;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  // waits for the frame to end; returns busy cycles and the first flags seen
  task automatic wait_idle(output int n, output logic abusy0, output logic dbusy0);
    logic [31:0] s, d;
    n = 0; abusy0 = 1'b0; dbusy0 = 1'b0;
    forever begin
      bus_read(2'd0, s); bus_read(2'd3, d);
      if (n == 0) begin abusy0 = s[0]; dbusy0 = d[31]; end
      if (!(s[0] | d[31])) break;
      n++;
      @(negedge clk);
    end
  endtask

  function automatic logic [63:0] exp_frame(input logic [1:0] op, input logic [4:0] p,
                                            input logic [4:0] dv, input logic [15:0] pl);
    return {32'hFFFF_FFFF, 2'b00, op, p, dv, (op == OPR) ? 2'b00 : 2'b10, pl};
  endfunction

  task automatic run_access(input logic [7:0] dv_div, input logic [1:0] op, input logic [4:0] p,
                            input logic [4:0] dv, input logic [15:0] pl, input logic here);
    int n; logic ab, db; logic [31:0] r;
    logic [63:0] mask, exp, exp_oe;
    bus_write(2'd0, {16'h0, dv_div, 8'h0});
    bus_write(2'd1, {16'h0, 3'b0, p, 3'b0, dv});
    cap_en = 1'b1; phy_bit = 0; rd_mode = (op == OPR); phy_here = here; phy_val = pl;
    if (op == OPA) bus_write(2'd2, {16'h0, pl});
    else if (op == OPW) bus_write(2'd3, {16'h0, pl});
    else begin
      bus_write(2'd1, {16'h0, 1'b1, 2'b0, p, 3'b0, dv});
      bus_read(2'd1, r);
      chk(r[15] == 1'b0 && r[12:8] == p && r[4:0] == dv, "R8 ctrl readback", {32'h0, r},
          {48'h0, 3'b0, p, 3'b0, dv});
    end
    wait_idle(n, ab, db);
    cap_en = 1'b0;
    mask = (op == OPR) ? {{46{1'b1}}, 18'h0} : '1;
    exp = exp_frame(op, p, dv, pl);
    exp_oe = (op == OPR) ? {{46{1'b1}}, 18'h0} : '1;
    if (op == OPA) begin
      chk(ab && !db, "R3 status busy flag", {62'h0, ab, db}, 64'h2);
      chk((cap_bits & mask) == (exp & mask), "R3 address frame bits", cap_bits, exp);
    end else if (op == OPW) begin
      chk(db && !ab, "R4 data busy flag", {62'h0, ab, db}, 64'h1);
      chk((cap_bits & mask) == (exp & mask), "R4 write frame bits", cap_bits, exp);
    end else begin
      chk(db && !ab, "R5 data busy flag", {62'h0, ab, db}, 64'h1);
      chk((cap_bits & mask) == (exp & mask), "R5 read frame bits", cap_bits & mask, exp & mask);
    end
    chk(cap_oe == exp_oe, "R5 drive enable pattern", cap_oe, exp_oe);
    chk(n == 128 * (int'(dv_div) + 1), "R9 busy duration", n, 128 * (int'(dv_div) + 1));
    chk(int'(t_r1 - t_r0) == 2 * (int'(dv_div) + 1) * CLK_PERIOD, "R2 MDC period",
        int'(t_r1 - t_r0), 2 * (int'(dv_div) + 1) * CLK_PERIOD);
    chk(!mdc && !mdio_oe, "R2 idle bus", {62'h0, mdc, mdio_oe}, 64'h0);
    if (op == OPR) begin
      bus_read(2'd3, r);
      chk(r[15:0] == (here ? pl : 16'hFFFF), "R5 R6 read data", r[15:0], here ? pl : 16'hFFFF);
      bus_read(2'd0, r);
      chk(r[1] == !here, "R6 error flag", r[1], !here);
    end
  endtask

  initial begin
    logic [31:0] r, d_before; int n; logic ab, db;
    bus_wr = 1'b0; bus_addr = 2'd0; bus_wdata = '0; mdio_i = 1'b1; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    bus_read(2'd0, r); chk(r == 32'h0000_6400, "R1 status reset", r, 32'h6400);
    bus_read(2'd3, r); chk(r == 32'h0, "R1 data reset", r, 0);
    chk(!mdc && !mdio_oe, "R1 pins reset", {62'h0, mdc, mdio_oe}, 0);

    foreach (VEC[i])
      run_access(VEC[i][36:29], VEC[i][28:27], VEC[i][26:22], VEC[i][21:17],
                 VEC[i][16:1], VEC[i][0]);

    // R2 R9 full divider value
    run_access(8'd100, OPA, 5'h05, 5'h01, 16'hC3C3, 1'b1);

    // R7 writes during a frame are dropped
    bus_write(2'd0, 32'h0000_0100);
    bus_write(2'd1, {16'h0, 3'b0, 5'h02, 3'b0, 5'h03});
    bus_read(2'd3, d_before);
    cap_en = 1'b1; phy_bit = 0; rd_mode = 1'b0;
    bus_write(2'd2, 32'h0000_0F0F);
    bus_write(2'd2, 32'h0000_AAAA);
    bus_write(2'd3, 32'h0000_5555);
    bus_write(2'd1, {16'h0, 1'b1, 2'b0, 5'h09, 3'b0, 5'h09});
    bus_write(2'd0, 32'h0000_0700);
    wait_idle(n, ab, db);
    repeat (20) @(negedge clk);
    cap_en = 1'b0;
    chk(phy_bit == 64, "R7 single frame", phy_bit, 64);
    bus_read(2'd2, r); chk(r == 32'h0F0F, "R7 address kept", r, 32'h0F0F);
    bus_read(2'd3, r); chk(r == d_before, "R7 data kept", r, d_before);
    bus_read(2'd1, r); chk(r == 32'h0203, "R7 control kept", r, 32'h0203);
    bus_read(2'd0, r); chk(r[15:8] == 8'd1 && r[0] == 1'b0, "R7 divider kept", r, 32'h0100);
    chk(cap_bits == exp_frame(OPA, 5'h02, 5'h03, 16'h0F0F), "R7 frame content", cap_bits,
        exp_frame(OPA, 5'h02, 5'h03, 16'h0F0F));

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule